// File: doc/BRIEF.md
# UART Receive Idle-Timeout Detector

This block sits beside the receiver of a running UART and decides when an incoming frame has ended. After a data character has been received it measures how long the line stays idle, in whole character periods whose length follows from the programmed frame format. When the run of idle characters reaches a programmable limit before another data character arrives, it emits a one-clock buffer-close pulse and an interrupt request. The buffer manager uses these to close the current receive buffer and alert the processor.

Idle time advances only on the bit-rate enable tick. A new data character clears all counts and starts a fresh measurement. A low level on the line in the middle of an idle character restarts that character's bit count. A limit of zero turns the feature off. The control is a three-state machine. DISARMED waits for the first data character. COUNTING measures idle time. FIRE lasts one clock and drives the outputs. The transitions are:

- arm (DISARMED to COUNTING, on a data character)
- rearm (COUNTING or FIRE to COUNTING, on a data character)
- hit (COUNTING to FIRE, when the final idle character completes)
- release (FIRE to DISARMED)

Top module: `uart_idle_timeout`

## Requirements
- R1: After reset both outputs are low and the detector is disarmed.
- R2: Before the first data-character strobe following reset, an idle line never produces a timeout, whatever the limit.
- R3: One idle character lasts `1 + D + P + S` ticks. D is `data_bits` as a binary count. P is 1 when `parity_en` is high. S is 2 when `two_stop` is high and 1 otherwise. A `data_bits` value below 5 is taken as 5, and a value above 9 is taken as 9.
- R4: While armed with a nonzero limit M, the timeout fires when M idle characters of line-high ticks have completed. Both outputs are high in the clock cycle after the edge that samples the completing tick.
- R5: `buf_close` and `irq` are single-cycle pulses and are asserted together.
- R6: After a timeout the detector stays disarmed, and produces no further pulse until another data-character strobe arrives.
- R7: A data-character strobe clears the bit count and the idle-character count and arms the detector. A tick sampled in the same cycle as the strobe is not counted.
- R8: A limit of zero suppresses the timeout and holds both counts at zero. Counting starts fresh from the first cycle the limit is nonzero.
- R9: A tick sampled with `rx_line` low restarts the current idle character's bit count from zero. Idle characters already completed are kept.
- R10: Cycles without a tick make no progress toward the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Bit-rate enable, one clock per bit time |
| rx_line | input | 1 | Receive line level, high when idle |
| char_rcvd | input | 1 | Data-character-received strobe |
| data_bits | input | 4 | Data bits per character (5 to 9) |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | High for two stop bits, low for one |
| max_idle | input | 16 | Idle characters to timeout; zero disables |
| buf_close | output | 1 | Buffer-close pulse |
| irq | output | 1 | Interrupt request pulse |

## Verification
Any error in the bit count or the idle-character count shifts the timeout pulse by a whole number of ticks. Because each test measures the exact latency from the strobe or enable to the pulse, a stuck, skipped or misclocked count shows up at the outputs on the first timeout it affects. A wrong state shows up sooner. A detector that is armed when it should be disarmed produces a pulse within one character period during the quiet windows. One that fails to rearm misses the next expected pulse entirely.

// File: rtl/uart_idle_pkg.sv
package uart_idle_pkg;

    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_COUNTING = 2'd1,
        ST_FIRE     = 2'd2
    } idle_state_e;

endpackage

// File: rtl/idle_char_len.sv
// Bit times in one idle character, derived from the frame format.
module idle_char_len #(
    parameter int DLEN_W   = 4,
    parameter int MIN_DATA = 5,
    parameter int MAX_DATA = 9,
    parameter int LEN_W    = 4
) (
    input  logic [DLEN_W-1:0] data_bits,
    input  logic              parity_en,
    input  logic              two_stop,
    output logic [LEN_W-1:0]  char_len
);

    logic [DLEN_W-1:0] eff_bits;

    always_comb begin
        if (data_bits < DLEN_W'(MIN_DATA))
            eff_bits = DLEN_W'(MIN_DATA);
        else if (data_bits > DLEN_W'(MAX_DATA))
            eff_bits = DLEN_W'(MAX_DATA);
        else
            eff_bits = data_bits;
    end

    always_comb begin
        char_len = LEN_W'(1) + LEN_W'(eff_bits) + LEN_W'(parity_en)
                 + (two_stop ? LEN_W'(2) : LEN_W'(1));
    end

endmodule

// File: rtl/idle_bit_timer.sv
// Counts line-high bit ticks within one idle character.
module idle_bit_timer #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             bit_tick,
    input  logic             rx_line,
    input  logic [LEN_W-1:0] char_len,
    output logic             char_done,
    output logic [LEN_W-1:0] bit_cnt
);

    logic at_end;
    logic active;

    assign active    = run && !clear;
    assign at_end    = (bit_cnt >= (char_len - LEN_W'(1)));
    assign char_done = active && bit_tick && rx_line && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (!active)
            bit_cnt <= '0;
        else if (bit_tick) begin
            if (!rx_line || at_end)
                bit_cnt <= '0;
            else
                bit_cnt <= bit_cnt + LEN_W'(1);
        end
    end

    // R9: a low line on a tick restarts the character
    a_r9_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_tick && !rx_line) |=> (bit_cnt == '0));

    // R10: no tick, no movement
    a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bit_tick) |=> $stable(bit_cnt));

endmodule

// File: rtl/idle_char_counter.sv
// Counts completed idle characters and flags the limit.
module idle_char_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             reached,
    output logic [CNT_W-1:0] char_cnt
);

    logic [CNT_W:0] nxt;

    assign nxt     = {1'b0, char_cnt} + (CNT_W+1)'(1);
    assign reached = step && (limit != '0) && (nxt >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            char_cnt <= '0;
        else if (clear)
            char_cnt <= '0;
        else if (step)
            char_cnt <= reached ? '0 : nxt[CNT_W-1:0];
    end

    // R7 / R8: a clear leaves the count at zero
    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (char_cnt == '0));

endmodule

// File: rtl/uart_idle_timeout.sv
module uart_idle_timeout
    import uart_idle_pkg::*;
#(
    parameter int MAX_IDLE_W    = 16,
    parameter int DLEN_W        = 4,
    parameter int MIN_DATA_BITS = 5,
    parameter int MAX_DATA_BITS = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_tick,
    input  logic                  rx_line,
    input  logic                  char_rcvd,
    input  logic [DLEN_W-1:0]     data_bits,
    input  logic                  parity_en,
    input  logic                  two_stop,
    input  logic [MAX_IDLE_W-1:0] max_idle,
    output logic                  buf_close,
    output logic                  irq
);

    localparam int MAX_CHAR_LEN = 1 + MAX_DATA_BITS + 1 + 2;
    localparam int LEN_W        = $clog2(MAX_CHAR_LEN + 1);

    idle_state_e           state_q, state_d;
    logic [LEN_W-1:0]      char_len;
    logic [LEN_W-1:0]      bit_cnt;
    logic [MAX_IDLE_W-1:0] char_cnt;
    logic                  run;
    logic                  char_done;
    logic                  hit;

    assign run = (state_q == ST_COUNTING) && (max_idle != '0);

    idle_char_len #(
        .DLEN_W  (DLEN_W),
        .MIN_DATA(MIN_DATA_BITS),
        .MAX_DATA(MAX_DATA_BITS),
        .LEN_W   (LEN_W)
    ) u_len (
        .data_bits(data_bits),
        .parity_en(parity_en),
        .two_stop (two_stop),
        .char_len (char_len)
    );

    idle_bit_timer #(
        .LEN_W(LEN_W)
    ) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (char_rcvd),
        .run      (run),
        .bit_tick (bit_tick),
        .rx_line  (rx_line),
        .char_len (char_len),
        .char_done(char_done),
        .bit_cnt  (bit_cnt)
    );

    idle_char_counter #(
        .CNT_W(MAX_IDLE_W)
    ) u_chars (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (char_rcvd || !run),
        .step    (char_done),
        .limit   (max_idle),
        .reached (hit),
        .char_cnt(char_cnt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: if (char_rcvd) state_d = ST_COUNTING;           // arm
            ST_COUNTING: begin
                if (char_rcvd)  state_d = ST_COUNTING;                   // rearm
                else if (hit)   state_d = ST_FIRE;                       // hit
            end
            ST_FIRE:     state_d = char_rcvd ? ST_COUNTING : ST_DISARMED; // rearm / release
            default:     state_d = ST_DISARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_DISARMED;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        buf_close = (state_q == ST_FIRE);
        irq       = (state_q == ST_FIRE);
    end

    // R5: one clock wide
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        buf_close |=> !buf_close);

    // R8: a zero limit never leads to a pulse
    a_r8_zero_never_fires: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_close) |-> ($past(max_idle) != '0));

    // R4: the pulse follows a line-high tick
    a_r4_fire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_close) |-> ($past(bit_tick) && $past(rx_line)));

    // R7: strobe clears counts and arms
    a_r7_strobe_arms: assert property (@(posedge clk) disable iff (!rst_n)
        char_rcvd |=> (state_q == ST_COUNTING && bit_cnt == '0 && char_cnt == '0));

endmodule

// File: tb/sim_uart_idle_timeout.sv
module sim_uart_idle_timeout;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        rx_line = 1'b1;
    logic        char_rcvd = 1'b0;
    logic [3:0]  data_bits = 4'd8;
    logic        parity_en = 1'b0;
    logic        two_stop = 1'b0;
    logic [15:0] max_idle = 16'd0;
    logic        buf_close;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    uart_idle_timeout u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line),
        .char_rcvd(char_rcvd), .data_bits(data_bits), .parity_en(parity_en),
        .two_stop(two_stop), .max_idle(max_idle), .buf_close(buf_close), .irq(irq)
    );

    // {data_bits[4], parity, two_stop, max_idle[16], expected ticks[14]}
    localparam logic [35:0] VEC [7] = '{
        {4'd8,  1'b0, 1'b0, 16'd3, 14'd30},
        {4'd5,  1'b0, 1'b0, 16'd1, 14'd7},
        {4'd9,  1'b1, 1'b1, 16'd2, 14'd26},
        {4'd7,  1'b1, 1'b0, 16'd4, 14'd40},
        {4'd6,  1'b0, 1'b1, 16'd5, 14'd45},
        {4'd3,  1'b0, 1'b0, 16'd2, 14'd14},
        {4'd12, 1'b0, 1'b0, 16'd1, 14'd11}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_fire(input int limit, output int c);
        c = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            char_rcvd = 1'b0;
            if (buf_close) begin
                c = i;
                break;
            end
        end
    endtask

    task automatic expect_quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            char_rcvd = 1'b0;
            if (buf_close || irq) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        chk(buf_close == 1'b0 && irq == 1'b0, "R1 reset outputs", buf_close, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(buf_close == 1'b0, "R1 after release", buf_close, 0);

        // R2: idle line before any character
        max_idle = 16'd1; bit_tick = 1'b1; rx_line = 1'b1;
        expect_quiet(60, "R2 no timeout before first char");

        // vector table: R3 R4 R5 R7
        for (int i = 0; i < 7; i++) begin
            data_bits = VEC[i][35:32];
            parity_en = VEC[i][31];
            two_stop  = VEC[i][30];
            max_idle  = VEC[i][29:14];
            bit_tick  = 1'b1; rx_line = 1'b1;
            char_rcvd = 1'b1;
            wait_fire(2000, c);
            chk(c == int'(VEC[i][13:0]) + 1, "R3/R4/R7 timeout latency", c, int'(VEC[i][13:0]) + 1);
            chk(irq == 1'b1, "R5 irq with buf_close", irq, 1);
            @(negedge clk);
            chk(buf_close == 1'b0 && irq == 1'b0, "R5 pulse one cycle", buf_close, 0);
        end

        // R6: stays disarmed after a timeout
        expect_quiet(80, "R6 disarmed after timeout");

        // R9: low line mid-character restarts bit count
        data_bits = 4'd8; parity_en = 1'b0; two_stop = 1'b0; max_idle = 16'd1;
        char_rcvd = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            char_rcvd = 1'b0;
        end
        rx_line = 1'b0;
        @(negedge clk);
        chk(buf_close == 1'b0, "R9 no pulse at low tick", buf_close, 0);
        rx_line = 1'b1;
        wait_fire(100, c);
        chk(c == 10, "R9 restart after low line", c, 10);

        // R9: completed idle characters are kept across a low tick
        max_idle = 16'd2;
        @(negedge clk);
        char_rcvd = 1'b1;
        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            char_rcvd = 1'b0;
        end
        rx_line = 1'b0;
        @(negedge clk);
        rx_line = 1'b1;
        wait_fire(100, c);
        chk(c == 10, "R9 completed characters kept", c, 10);

        // R7: a new character mid-count restarts the measurement
        @(negedge clk);
        char_rcvd = 1'b1;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            char_rcvd = 1'b0;
            if (buf_close) chk(1'b0, "R7 early pulse", 1, 0);
        end
        char_rcvd = 1'b1;
        wait_fire(100, c);
        chk(c == 21, "R7 restart on new char", c, 21);

        // R8: zero limit disables, counting fresh once nonzero
        @(negedge clk);
        max_idle = 16'd0;
        char_rcvd = 1'b1;
        expect_quiet(120, "R8 zero limit quiet");
        max_idle = 16'd2;
        wait_fire(100, c);
        chk(c == 20, "R8 fresh count after enable", c, 20);

        // R10: no ticks, no progress
        @(negedge clk);
        max_idle = 16'd1; bit_tick = 1'b0;
        char_rcvd = 1'b1;
        expect_quiet(40, "R10 no tick no timeout");
        bit_tick = 1'b1;
        wait_fire(100, c);
        chk(c == 10, "R10 resume with ticks", c, 10);

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule